// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers eight level-sensitive hardware interrupt lines. It keeps a status word and a cause word in the fixed bit layout that handler software expects. A source may raise a request to the core only when it is pending, unmasked and the global enable is set. The block then reports the highest-numbered such source as the index to service.

When the core takes an interrupt, it pulses the accept strobe. The controller then pushes the current mask onto a LIFO and clears the mask bits of the selected level and of every level below it. It also sets the global enable, so that only sources of higher priority can nest. A return strobe clears the enable and pops the saved mask, which unwinds one nesting level. Software may rewrite the mode, enable and mask bits in the status word, and the code and branch-delay fields in the cause word. The pending field always mirrors the interrupt lines.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The status word has the mask in bits 15:8, user mode in bit 4, exception level in bit 1 and global enable in bit 0. The cause word has pending in bits 15:8, the exception code in bits 6:2 and branch-delay in bit 31. All other bits read 0. Every field is 0 after reset.
- R2: The pending field equals the interrupt lines sampled at the previous clock edge. A write to the cause word never changes the pending field.
- R3: `irq_req_o` is 1 exactly when global enable is 1 and at least one candidate bit is set.
- R4: The candidate set is the bitwise AND of the pending field and the mask field.
- R5: `irq_idx_o` is the position of the highest-numbered candidate bit, and 0 when there is no candidate.
- R6: An accept is a cycle in which `accept_i` and `irq_req_o` are both 1. It pushes the mask onto the stack, clears mask bits idx down to 0, keeps the bits above idx, and sets global enable. `accept_i` while `irq_req_o` is 0 has no effect.
- R7: A return is a cycle in which `return_i` is 1 and no accept occurs. It clears global enable and loads the mask from the stack top, popping it. On an empty stack the mask is left unchanged.
- R8: An accept loads the exception code with 0. This wins over a cause write in the same cycle.
- R9: The stack holds `STACK_DEPTH` masks (8 by default) in LIFO order. A push onto a full stack is dropped but the mask still changes as in R6. The push sets `stack_ovf_o`, which stays 1 until reset.
- R10: A status write loads the mask, user mode, exception level and enable from the same bit positions, but only in a cycle with no accept and no return. A cause write loads the branch-delay bit, and also the code when no accept occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 8 | Level interrupt lines |
| accept_i | input | 1 | Core takes the requested interrupt |
| return_i | input | 1 | Core leaves the current handler |
| status_we_i | input | 1 | Status word write enable |
| status_wdata_i | input | 32 | Status write data |
| cause_we_i | input | 1 | Cause word write enable |
| cause_wdata_i | input | 32 | Cause write data |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_idx_o | output | 3 | Selected source index |
| status_o | output | 32 | Status word |
| cause_o | output | 32 | Cause word |
| stack_ovf_o | output | 1 | Sticky mask-stack overflow |

## Verification
Every register in the block updates on the edge that samples its inputs. The status and cause words therefore show the effect of a strobe, a write or a line change one clock edge later. `irq_req_o` and `irq_idx_o` are combinational from those registers and settle in the same cycle. The bench drives inputs at the falling edge and advances its model across the next rising edge. It then compares every output at the following falling edge, so each result is sampled one full edge after its stimulus. The directed part nests all eight levels, forces an overflow and unwinds past an empty stack. Fixed-seed random traffic then mixes strobes and writes that collide in the same cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NUM_SRC  = 8;
  localparam int unsigned IDX_W    = $clog2(NUM_SRC);
  localparam int unsigned CODE_W   = 5;

  localparam int unsigned ST_IE    = 0;
  localparam int unsigned ST_EXL   = 1;
  localparam int unsigned ST_UM    = 4;
  localparam int unsigned FLD_LO   = 8;
  localparam int unsigned CA_CODE  = 2;
  localparam int unsigned CA_BD    = 31;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef struct packed {
    src_vec_t mask;
    logic     um;
    logic     exl;
    logic     ie;
  } status_t;

  function automatic logic [31:0] pack_status(status_t s);
    logic [31:0] w;
    w = '0;
    w[FLD_LO +: NUM_SRC] = s.mask;
    w[ST_UM]  = s.um;
    w[ST_EXL] = s.exl;
    w[ST_IE]  = s.ie;
    return w;
  endfunction

  function automatic logic [31:0] pack_cause(src_vec_t pend, logic [CODE_W-1:0] code,
                                             logic bd);
    logic [31:0] w;
    w = '0;
    w[FLD_LO +: NUM_SRC]  = pend;
    w[CA_CODE +: CODE_W]  = code;
    w[CA_BD]              = bd;
    return w;
  endfunction
endpackage

// File: rtl/prio_irq_select.sv
module prio_irq_select
  import prio_irq_pkg::*;
(
  input  src_vec_t         pend_i,
  input  src_vec_t         mask_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output src_vec_t         keep_o
);
  src_vec_t cand;

  assign cand  = pend_i & mask_i;
  assign any_o = |cand;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(NUM_SRC); i++) begin
      if (cand[i]) idx_o = IDX_W'(i);
    end
  end

  // bits strictly above the selected level survive an accept
  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_keep
    assign keep_o[g] = IDX_W'(g) > idx_o;
  end
endmodule

// File: rtl/prio_irq_mask_stack.sv
module prio_irq_mask_stack #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] sp_q;
  logic             full;

  assign full    = sp_q == FULL_LVL;
  assign empty_o = sp_q == '0;

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (push_i && !full && sp_q == PTR_W'(g)) mem_q[g] <= data_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (sp_q == PTR_W'(i + 1)) top_o = mem_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      ovf_o <= 1'b0;
    end else if (push_i) begin
      if (full) ovf_o <= 1'b1;
      else      sp_q  <= sp_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      sp_q <= sp_q - 1'b1;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       irq_lines_i,
  input  logic             accept_i,
  input  logic             return_i,
  input  logic             status_we_i,
  input  logic [31:0]      status_wdata_i,
  input  logic             cause_we_i,
  input  logic [31:0]      cause_wdata_i,
  output logic             irq_req_o,
  output logic [2:0]       irq_idx_o,
  output logic [31:0]      status_o,
  output logic [31:0]      cause_o,
  output logic             stack_ovf_o
);
  status_t           st_q;
  src_vec_t          pend_q;
  logic [CODE_W-1:0] code_q;
  logic              bd_q;

  logic              any;
  logic [IDX_W-1:0]  idx;
  src_vec_t          keep;
  src_vec_t          saved;
  logic              stk_empty;
  logic              take_acc, take_ret;

  prio_irq_select u_sel (
    .pend_i (pend_q),
    .mask_i (st_q.mask),
    .any_o  (any),
    .idx_o  (idx),
    .keep_o (keep)
  );

  prio_irq_mask_stack #(.W(NUM_SRC), .DEPTH(STACK_DEPTH)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (take_acc),
    .pop_i   (take_ret),
    .data_i  (st_q.mask),
    .top_o   (saved),
    .empty_o (stk_empty),
    .ovf_o   (stack_ovf_o)
  );

  assign irq_req_o = st_q.ie & any;
  assign irq_idx_o = idx;
  assign take_acc  = accept_i & irq_req_o;
  assign take_ret  = return_i & ~take_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      pend_q <= '0;
      code_q <= '0;
      bd_q   <= 1'b0;
    end else begin
      pend_q <= irq_lines_i;
      if (take_acc) begin
        st_q.mask <= st_q.mask & keep;
        st_q.ie   <= 1'b1;
      end else if (take_ret) begin
        st_q.ie <= 1'b0;
        if (!stk_empty) st_q.mask <= saved;
      end else if (status_we_i) begin
        st_q.mask <= status_wdata_i[FLD_LO +: NUM_SRC];
        st_q.um   <= status_wdata_i[ST_UM];
        st_q.exl  <= status_wdata_i[ST_EXL];
        st_q.ie   <= status_wdata_i[ST_IE];
      end
      if (cause_we_i) bd_q <= cause_wdata_i[CA_BD];
      if (take_acc)        code_q <= '0;
      else if (cause_we_i) code_q <= cause_wdata_i[CA_CODE +: CODE_W];
    end
  end

  assign status_o = pack_status(st_q);
  assign cause_o  = pack_cause(pend_q, code_q, bd_q);
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  irq_lines_i,
  input logic        accept_i,
  input logic        return_i,
  input logic        irq_req_o,
  input logic [2:0]  irq_idx_o,
  input logic [31:0] status_o,
  input logic [31:0] cause_o,
  input logic        stack_ovf_o
);
  logic [7:0] cand;
  logic [7:0] above;
  logic       acc;

  assign cand = cause_o[15:8] & status_o[15:8];
  assign acc  = accept_i && irq_req_o;
  always_comb for (int i = 0; i < 8; i++) above[i] = 3'(i) > irq_idx_o;

  assert_pend_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> cause_o[15:8] == $past(irq_lines_i));

  assert_req_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[0] |-> !irq_req_o);

  assert_idx_highest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> ((cand >> irq_idx_o) == 8'd1));

  assert_accept_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (status_o[15:8] == ($past(status_o[15:8]) & $past(above))) && status_o[0]);

  assert_return_ie_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (return_i && !acc) |=> !status_o[0]);

  assert_code_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> cause_o[6:2] == 5'd0);

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_ovf_o |=> stack_ovf_o);
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_lines_i (irq_lines_i),
  .accept_i    (accept_i),
  .return_i    (return_i),
  .irq_req_o   (irq_req_o),
  .irq_idx_o   (irq_idx_o),
  .status_o    (status_o),
  .cause_o     (cause_o),
  .stack_ovf_o (stack_ovf_o)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_lines_i = '0;
  logic        accept_i = 1'b0, return_i = 1'b0;
  logic        status_we_i = 1'b0, cause_we_i = 1'b0;
  logic [31:0] status_wdata_i = '0, cause_wdata_i = '0;
  logic        irq_req_o, stack_ovf_o;
  logic [2:0]  irq_idx_o;
  logic [31:0] status_o, cause_o;

  int checks = 0, failures = 0;

  // model state
  logic [7:0] m_mask, m_pend;
  logic       m_ie, m_um, m_exl, m_bd, m_ovf;
  logic [4:0] m_code;
  logic [7:0] m_stk [8];
  int         m_sp;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_lines_i(irq_lines_i),
    .accept_i(accept_i), .return_i(return_i),
    .status_we_i(status_we_i), .status_wdata_i(status_wdata_i),
    .cause_we_i(cause_we_i), .cause_wdata_i(cause_wdata_i),
    .irq_req_o(irq_req_o), .irq_idx_o(irq_idx_o),
    .status_o(status_o), .cause_o(cause_o), .stack_ovf_o(stack_ovf_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] hi_idx(logic [7:0] v);
    logic [2:0] r = '0;
    for (int i = 0; i < 8; i++) if (v[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [31:0] exp_status();
    return {16'b0, m_mask, 3'b0, m_um, 2'b0, m_exl, m_ie};
  endfunction

  function automatic logic [31:0] exp_cause();
    return {m_bd, 15'b0, m_pend, 1'b0, m_code, 2'b0};
  endfunction

  task automatic compare();
    logic [7:0] c;
    logic       rq;
    c  = m_pend & m_mask;
    rq = m_ie && (c != 0);
    chk("R1 R6 R7 R10 status", status_o, exp_status());
    chk("R1 R2 R8 R10 cause", cause_o, exp_cause());
    chk("R3 R4 request", {31'b0, irq_req_o}, {31'b0, rq});
    chk("R5 index", {29'b0, irq_idx_o}, {29'b0, hi_idx(c)});
    chk("R9 overflow", {31'b0, stack_ovf_o}, {31'b0, m_ovf});
  endtask

  // model one rising edge from current inputs, then check at next falling edge
  task automatic advance();
    logic [7:0] c;
    logic       acc, ret;
    c   = m_pend & m_mask;
    acc = accept_i && m_ie && (c != 0);
    ret = return_i && !acc;
    if (acc) begin
      if (m_sp < 8) begin m_stk[m_sp] = m_mask; m_sp++; end
      else m_ovf = 1'b1;
      for (int i = 0; i < 8; i++) if (i <= int'(hi_idx(c))) m_mask[i] = 1'b0;
      m_ie = 1'b1;
      m_code = 5'd0;
    end else if (ret) begin
      m_ie = 1'b0;
      if (m_sp > 0) begin m_sp--; m_mask = m_stk[m_sp]; end
    end else if (status_we_i) begin
      m_mask = status_wdata_i[15:8];
      m_um   = status_wdata_i[4];
      m_exl  = status_wdata_i[1];
      m_ie   = status_wdata_i[0];
    end
    if (cause_we_i) begin
      m_bd = cause_wdata_i[31];
      if (!acc) m_code = cause_wdata_i[6:2];
    end
    m_pend = irq_lines_i;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    accept_i = 0; return_i = 0; status_we_i = 0; cause_we_i = 0;
  endtask

  task automatic wr_status(logic [7:0] mask, logic ie);
    idle();
    status_we_i = 1; status_wdata_i = {16'hFFFF, mask, 8'h00} | {31'b0, ie};
    advance();
    idle();
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    m_mask = 0; m_pend = 0; m_ie = 0; m_um = 0; m_exl = 0; m_bd = 0; m_ovf = 0;
    m_code = 0; m_sp = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    compare(); // R1 reset state

    // R3: lines set but enable 0 -> no request
    irq_lines_i = 8'h81;
    advance();
    chk("R3 no request while disabled", {31'b0, irq_req_o}, 32'd0);

    // R6: accept without request is ignored
    accept_i = 1; advance(); idle();

    // R2: pending write ignored
    cause_we_i = 1; cause_wdata_i = 32'h8000_FF7C; irq_lines_i = 8'h00;
    advance(); idle();
    chk("R2 pending ignores write", {24'b0, cause_o[15:8]}, 32'd0);

    // R9: nest all eight levels, lowest first
    wr_status(8'hFF, 1'b1);
    for (int k = 0; k < 8; k++) begin
      irq_lines_i = 8'(1 << k);
      advance();
      chk("R5 nested index", {29'b0, irq_idx_o}, 32'(k));
      accept_i = 1; advance(); idle();
    end
    chk("R6 mask empty after full nest", {24'b0, status_o[15:8]}, 32'd0);
    wr_status(8'hFF, 1'b1);
    irq_lines_i = 8'h80; advance();
    accept_i = 1; advance(); idle();
    chk("R9 overflow flagged", {31'b0, stack_ovf_o}, 32'd1);
    irq_lines_i = 8'h00;
    for (int k = 0; k < 9; k++) begin
      return_i = 1; advance(); idle();
    end
    chk("R7 R9 mask after unwinding", {24'b0, status_o[15:8]}, 32'hFF);
    chk("R7 enable cleared", {31'b0, status_o[0]}, 32'd0);

    // R8 R10: accept and cause write collide
    wr_status(8'hF0, 1'b1);
    irq_lines_i = 8'h30; advance();
    accept_i = 1; cause_we_i = 1; cause_wdata_i = 32'h0000_007C;
    status_we_i = 1; status_wdata_i = 32'h0000_FF13;
    advance(); idle();
    chk("R8 code cleared on accept", {27'b0, cause_o[6:2]}, 32'd0);
    chk("R10 status write blocked by accept", {24'b0, status_o[15:8]}, 32'hC0);

    seed = $urandom(32'd4242);
    for (int n = 0; n < 4000; n++) begin
      irq_lines_i    = 8'($urandom);
      accept_i       = ($urandom % 3) == 0;
      return_i       = ($urandom % 5) == 0;
      status_we_i    = ($urandom % 8) == 0;
      status_wdata_i = $urandom | (($urandom % 4) != 0 ? 32'd1 : 32'd0);
      cause_we_i     = ($urandom % 8) == 0;
      cause_wdata_i  = $urandom;
      advance();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule